// File: doc/BRIEF.md
# Serial Management Interface Master (Clause 22)

This block lets a processor reach the management registers of attached Ethernet PHYs over the two-wire MDC/MDIO bus. Software uses two 32-bit registers. A configuration word selects Clause 22 framing, sets the MDC divider and can drop the preamble. A command word holds the operation, the PHY address, the register address and 16 data bits, along with a start flag that doubles as the busy indicator.

Setting the start flag launches one serial frame. The block derives MDC from its own clock, shifts the frame out MSB first, and releases MDIO to the PHY for the turnaround and data phases of a read. It captures the returned bits into the data field of the command word. If the PHY leaves the line high when it should have pulled it low in the turnaround, a read-fail flag is set. Completion is signalled by the busy flag dropping.

Top module: `mdio_master`

## Requirements
- R1: After reset the command word reads 0x00000000, the configuration word reads 0x00000301 (Clause 22 select = 1, divider = 48, preamble suppress = 0), MDC is low and the MDIO output enable is low.
- R2: The command word is at byte offset 0x0 and the configuration word at 0x4. Command fields: [29] start/busy, [28] read-fail (read-only), [27:26] operation, [25:21] PHY address, [20:16] register address, [15:0] data. Configuration fields: [12] preamble suppress, [9:4] divider N, [0] Clause 22 select. All other bits read as zero.
- R3: A command write with bit 29 set, accepted while idle and with Clause 22 select at 1, sets busy in the next cycle. Busy clears exactly F·2·(N+1) clock cycles after the accepting edge, where F is 64 with the preamble and 32 without it.
- R4: MDC is low whenever the block is idle. During a frame, MDC first rises N+1 cycles after the accepting edge and then alternates N+1 cycles high and N+1 cycles low.
- R5: A write frame (operation value 1) drives, MSB first, 32 ones, then 01, the 2-bit operation, the PHY address, the register address, turnaround 10 and the 16 data bits. Each bit is driven with the output enable high and changes only when MDC falls.
- R6: With preamble suppress set, the frame omits the 32 ones and starts directly with 01. It is 32 bits long.
- R7: For a read frame (operation value 2), the output enable is low for both turnaround bits and all 16 data bits, and stays low until the frame ends. MDIO is sampled on each rising MDC edge of the data bits, MSB first. After completion, command bits [15:0] hold the sampled value.
- R8: Read-fail (bit 28) is set when MDIO is high at the rising MDC edge of the second turnaround bit of a read. It is cleared when the next frame starts. A command write that does not start a frame leaves it unchanged.
- R9: A write to the command word while busy changes no field and does not disturb the running frame or its length.
- R10: A command write with bit 29 set while Clause 22 select is 0 stores the fields but starts no frame. Busy stays 0 and MDC stays low.
- R11: The divider and preamble setting are captured when a frame starts. Configuration writes made during the frame change the readback value but not the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W (3) | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data of the addressed register (combinational) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO value driven when enabled |
| mdioOe | output | 1 | MDIO output enable (low = released) |
| mdioIn | input | 1 | MDIO line value |

## Verification
Every timing result follows from the accepting edge E0 of the start write. MDC rises at E0+(N+1). Each bit lasts 2·(N+1) cycles. Busy drops at E0+F·2·(N+1). The bench records E0 with a cycle counter and polls busy at every falling clock edge after it, and it requires the first zero at exactly the computed count. Frame bits are captured on each rising MDC edge, where the block guarantees stability. The bench presents each PHY response bit during the preceding low phase, so the value is in place N+1 cycles before it is sampled. Readback of data and read-fail happens only after busy has been seen low.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // Frame geometry of a Clause 22 management frame
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int SHORT_BITS = FRAME_BITS - PRE_BITS;
  localparam int DATA_BITS  = 16;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  // Control-to-datapath strobes
  typedef struct packed {
    logic             active;      // frame in progress (busy)
    logic             sampleTa;    // rising MDC in second turnaround bit
    logic             sampleData;  // rising MDC in a data bit
    logic [IDX_W-1:0] bitIdx;      // frame bit currently on the wire
  } mdio_strobe_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [DIV_W-1:0] divN,
  input  logic             noPreamble,
  output logic             mdc,
  output mdio_strobe_t     strobe
);
  localparam logic [IDX_W-1:0] LONG_TOP  = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] SHORT_TOP = IDX_W'(SHORT_BITS - 1);
  localparam logic [IDX_W-1:0] TA_IDX    = IDX_W'(DATA_BITS);

  logic             active;
  logic             mdcQ;
  logic [DIV_W-1:0] halfCnt;
  logic [DIV_W-1:0] divLatched;
  logic [IDX_W-1:0] bitIdx;

  logic tick, riseEv, fallEv, lastBit;

  always_comb begin
    tick    = active && (halfCnt == divLatched);
    riseEv  = tick && !mdcQ;
    fallEv  = tick && mdcQ;
    lastBit = (bitIdx == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active     <= 1'b0;
      mdcQ       <= 1'b0;
      halfCnt    <= '0;
      divLatched <= '0;
      bitIdx     <= '0;
    end else if (startReq) begin
      active     <= 1'b1;
      mdcQ       <= 1'b0;
      halfCnt    <= '0;
      divLatched <= divN;
      bitIdx     <= noPreamble ? SHORT_TOP : LONG_TOP;
    end else if (active) begin
      if (tick) begin
        halfCnt <= '0;
        mdcQ    <= !mdcQ;
        if (fallEv) begin
          if (lastBit) active <= 1'b0;
          else         bitIdx <= bitIdx - 1'b1;
        end
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  always_comb begin
    mdc               = mdcQ;
    strobe.active     = active;
    strobe.bitIdx     = bitIdx;
    strobe.sampleTa   = riseEv && (bitIdx == TA_IDX);
    strobe.sampleData = riseEv && (bitIdx < TA_IDX);
  end
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int CMD_OFS = 0,
  parameter int CFG_OFS = 4,
  parameter int DIV_W   = 6,
  parameter int DEF_DIV = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  mdio_strobe_t      strobe,
  input  logic              mdioIn,
  output logic              startReq,
  output logic [DIV_W-1:0]  divN,
  output logic              noPreamble,
  output logic              mdioOut,
  output logic              mdioOe
);
  localparam logic [1:0]        OP_READ  = 2'b10;
  localparam logic [IDX_W-1:0]  TA_HI    = IDX_W'(DATA_BITS + 1);
  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(CMD_OFS);
  localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(CFG_OFS);

  logic [1:0]           opQ;
  logic [4:0]           phyQ;
  logic [4:0]           regQ;
  logic [DATA_BITS-1:0] dataQ;
  logic                 readFailQ;
  logic                 cfgC22;
  logic [DIV_W-1:0]     cfgDiv;
  logic                 cfgNoPre;

  logic cmdHit, cfgHit, cmdWrOk, isRead, driveEn;
  logic [FRAME_BITS-1:0] frameWord;
  logic unusedWrBits;

  always_comb begin
    cmdHit   = regWrEn && (regAddr == CMD_ADDR);
    cfgHit   = regWrEn && (regAddr == CFG_ADDR);
    cmdWrOk  = cmdHit && !strobe.active;
    startReq = cmdWrOk && regWrData[29] && cfgC22;
    isRead   = (opQ == OP_READ);
    unusedWrBits = ^{regWrData[31:30], regWrData[28], regWrData[11:10], regWrData[3:1]};
  end

  // Command fields, read capture and read-fail flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ       <= '0;
      phyQ      <= '0;
      regQ      <= '0;
      dataQ     <= '0;
      readFailQ <= 1'b0;
    end else begin
      if (cmdWrOk) begin
        opQ   <= regWrData[27:26];
        phyQ  <= regWrData[25:21];
        regQ  <= regWrData[20:16];
        dataQ <= regWrData[15:0];
      end else if (strobe.sampleData && isRead) begin
        dataQ <= {dataQ[DATA_BITS-2:0], mdioIn};
      end
      if (startReq) readFailQ <= 1'b0;
      else if (strobe.sampleTa && isRead) readFailQ <= mdioIn;
    end
  end

  // Configuration word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgC22   <= 1'b1;
      cfgDiv   <= DIV_W'(DEF_DIV);
      cfgNoPre <= 1'b0;
    end else if (cfgHit) begin
      cfgC22   <= regWrData[0];
      cfgDiv   <= regWrData[4 +: DIV_W];
      cfgNoPre <= regWrData[12];
    end
  end

  // Serial output: frame bit selected by the control's index
  always_comb begin
    frameWord = {{PRE_BITS{1'b1}}, 2'b01, opQ, phyQ, regQ,
                 (isRead ? 2'b11 : 2'b10), dataQ};
    driveEn   = strobe.active && !(isRead && (strobe.bitIdx <= TA_HI));
    mdioOe    = driveEn;
    mdioOut   = driveEn && frameWord[strobe.bitIdx];
    divN      = cfgDiv;
    noPreamble = cfgNoPre;
  end

  // Register readback
  always_comb begin
    if (regAddr == CMD_ADDR)
      regRdData = {2'b00, strobe.active, readFailQ, opQ, phyQ, regQ, dataQ};
    else if (regAddr == CFG_ADDR)
      regRdData = {19'b0, cfgNoPre, 2'b00, cfgDiv, 3'b000, cfgC22};
    else
      regRdData = '0;
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int CMD_OFS = 0,
  parameter int CFG_OFS = 4,
  parameter int DEF_DIV = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  localparam int DIV_W = 6;  // field [9:4] of the configuration word

  mdio_strobe_t     strobe;
  logic             startReq;
  logic [DIV_W-1:0] divN;
  logic             noPreamble;
  logic             busy;

  assign busy = strobe.active;

  mdio_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .divN       (divN),
    .noPreamble (noPreamble),
    .mdc        (mdc),
    .strobe     (strobe)
  );

  mdio_datapath #(
    .ADDR_W  (ADDR_W),
    .CMD_OFS (CMD_OFS),
    .CFG_OFS (CFG_OFS),
    .DIV_W   (DIV_W),
    .DEF_DIV (DEF_DIV)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .strobe     (strobe),
    .mdioIn     (mdioIn),
    .startReq   (startReq),
    .divN       (divN),
    .noPreamble (noPreamble),
    .mdioOut    (mdioOut),
    .mdioOe     (mdioOe)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int ADDR_W  = 3,
  parameter int CMD_OFS = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              startReq,
  input logic              mdc,
  input logic              mdioOut,
  input logic              mdioOe,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regRdData
);
  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(CMD_OFS);

  // R3
  start_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> (busy && !mdc));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe));

  // R5
  out_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && (!$stable(mdioOut) || !$stable(mdioOe))) |-> $fell(mdc));

  // R7
  release_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && $past(!mdioOe)) |-> !mdioOe);

  // R9
  busy_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((regAddr == CMD_ADDR) && $past(regWrEn && (regAddr == CMD_ADDR) && busy))
      |-> $stable(regRdData[27:16]));
endmodule

bind mdio_master mdio_master_chk #(.ADDR_W(ADDR_W), .CMD_OFS(CMD_OFS)) u_chk (.*);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] CMD = 3'd0;
  localparam logic [2:0] CFG = 3'd4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = CMD;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;
  int tAccept = 0;
  int firstRise = -1;
  logic [63:0] gotOut, gotOe;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  mdio_master dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = CMD;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdData;
    regAddr = CMD;
  endtask

  task automatic setCfg(input int n, input bit noPre);
    wr(CFG, {19'b0, noPre, 2'b00, 6'(n), 3'b000, 1'b1});
  endtask

  // PHY model: presents each response bit during the low phase, records outputs at rising MDC
  task automatic phyModel(input int nb, input logic taVal, input logic [15:0] resp);
    gotOut = '0; gotOe = '0; firstRise = -1;
    for (int i = nb - 1; i >= 0; i--) begin
      mdioIn = (i == 16) ? taVal : ((i < 16) ? resp[i] : 1'b1);
      @(posedge mdc);
      if (firstRise < 0) firstRise = cyc - tAccept;
      gotOut[i] = mdioOut;
      gotOe[i]  = mdioOe;
      @(negedge mdc);
    end
    mdioIn = 1'b1;
  endtask

  task automatic runTx(input int n, input bit noPre, input logic [1:0] op,
                       input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] data,
                       input logic taVal, input logic [15:0] resp,
                       input int intrudeAt, input logic [2:0] intrudeAddr,
                       input logic [31:0] intrudeData, input string tag);
    int nb, expT, k;
    bit isRd, busyNow;
    logic [63:0] expBits, expOe, lenMask;
    logic [31:0] v;
    nb   = noPre ? 32 : 64;
    expT = nb * 2 * (n + 1);
    isRd = (op == 2'b10);
    expBits = {32'hFFFF_FFFF, 2'b01, op, phy, rg, (isRd ? 2'b00 : 2'b10), data};
    lenMask = noPre ? 64'h0000_0000_FFFF_FFFF : '1;
    expOe   = isRd ? (lenMask & ~64'h3FFFF) : lenMask;
    @(negedge clk);
    regAddr = CMD; regWrData = {2'b00, 1'b1, 1'b0, op, phy, rg, data}; regWrEn = 1'b1;
    k = 0;
    fork
      phyModel(nb, taVal, resp);
      begin
        @(negedge clk);
        regWrEn = 1'b0;
        tAccept = cyc;
        busyNow = 1'b1;
        while (busyNow && k < expT + 100) begin
          @(negedge clk);
          regWrEn = 1'b0; regAddr = CMD;
          #1;
          k++;
          busyNow = regRdData[29];
          if (k == intrudeAt) begin
            regAddr = intrudeAddr; regWrData = intrudeData; regWrEn = 1'b1;
          end
        end
      end
    join
    check({tag, " R3 busy span"}, 64'(k), 64'(expT));
    check({tag, " R4 first MDC rise"}, 64'(firstRise), 64'(n + 1));
    check({tag, " R5/R6/R7 output enable pattern"}, gotOe, expOe);
    check({tag, " R5/R6 frame bits"}, gotOut & expOe, expBits & expOe);
    rd(CMD, v);
    check({tag, " R7/R8 command readback"}, 64'(v),
          64'({2'b00, 1'b0, (isRd ? taVal : 1'b0), op, phy, rg, (isRd ? resp : data)}));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(CMD, v); check("R1 command after reset", 64'(v), 64'h0);
    rd(CFG, v); check("R1 configuration after reset", 64'(v), 64'h301);
    check("R1 MDC/OE idle after reset", {62'b0, mdc, mdioOe}, 64'h0);

    // R2 layout and readback
    wr(CFG, 32'hFFFF_FFFF);
    rd(CFG, v); check("R2 configuration field mask", 64'(v), 64'h13F1);
    wr(CMD, 32'hDABC_D123);
    rd(CMD, v); check("R2 command fields, no start, read-fail not writable", 64'(v), 64'h0ABC_D123);

    // Sweep: divider x preamble x operation
    for (int ni = 0; ni < 3; ni++) begin
      for (int p = 0; p < 2; p++) begin
        for (int o = 1; o <= 2; o++) begin
          int n;
          n = (ni == 2) ? 3 : ni;
          setCfg(n, p[0]);
          runTx(n, p[0], 2'(o), 5'(5 + 9 * n + o), 5'(31 - 3 * n - o),
                16'hA55A ^ 16'(n * 257 + o * 4369 + p),
                1'b0, 16'h3C96 ^ 16'(n * 73 + o + p * 1000),
                -1, CMD, 32'h0, $sformatf("sweep n=%0d pre_off=%0d op=%0d", n, p, o));
        end
      end
    end

    // R8 missing turnaround response
    setCfg(1, 1'b0);
    runTx(1, 1'b0, 2'b10, 5'd17, 5'd1, 16'h0000, 1'b1, 16'hBEEF, -1, CMD, 32'h0, "R8 fail read");
    wr(CMD, 32'h0612_3456);
    rd(CMD, v); check("R8 read-fail kept by non-start write", 64'(v), 64'h1612_3456);
    runTx(1, 1'b0, 2'b01, 5'd2, 5'd3, 16'h00FF, 1'b0, 16'h0, -1, CMD, 32'h0, "R8 cleared by next start");

    // R9 command write while busy
    setCfg(2, 1'b1);
    runTx(2, 1'b1, 2'b01, 5'd9, 5'd22, 16'h5A01, 1'b0, 16'h0, 5, CMD, 32'h2FFF_FFFF, "R9 busy write");

    // R11 configuration change mid-frame
    setCfg(1, 1'b0);
    runTx(1, 1'b0, 2'b01, 5'd30, 5'd7, 16'h8001, 1'b0, 16'h0, 7, CFG,
          32'h0000_1051, "R11 cfg during frame");
    rd(CFG, v); check("R11 configuration takes new value", 64'(v), 64'h1051);

    // R10 start with Clause 22 select clear
    wr(CFG, 32'h0000_0010);
    wr(CMD, 32'h2123_4567);
    begin
      bit sawActivity;
      sawActivity = 1'b0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        rd(CMD, v);
        if (mdc || mdioOe || v[29]) sawActivity = 1'b1;
      end
      check("R10 no frame without Clause 22 select", 64'(sawActivity), 64'h0);
    end
    rd(CMD, v); check("R10 fields stored", 64'(v), 64'h0123_4567);

    // Slow divider at the reset value, preamble suppressed
    setCfg(48, 1'b1);
    runTx(48, 1'b1, 2'b10, 5'd1, 5'd2, 16'h0, 1'b0, 16'h7E81, -1, CMD, 32'h0, "R4 default divider");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule